// File: doc/BRIEF.md
# Double-Data-Rate Nibble 8b/10b Framing Encoder

This block sits behind a five-lane double-data-rate capture stage. Each lane delivers one sample on the rising half and one on the falling half of the parallel clock, so each clock period supplies two five-bit samples. Two consecutive clock periods make one code group. In the encoded mode, lane 4 is a data-valid flag and lanes 3..0 carry nibbles. The four nibbles of a group form a 16-bit word. The word is split into a high byte and a low byte, and each byte is coded with the standard 8b/10b code under one running disparity. The result is a 20-bit code group.

When the flag lane requests it, the data nibbles are dropped and a control character fills both code fields instead. This character is a comma by default and can be replaced through a one-byte register. A bypass mode skips the coding and passes the twenty raw lane bits of the group through unchanged. Each finished group appears with a one-cycle valid strobe. Serializing the code groups and capturing the lanes are left to the neighbouring blocks.

Top module: `ddrnib_framer`

## Requirements
- R1: After reset, `code_valid` is 0, `code_out` is 0 and the running disparity is negative, so a first comma group after reset starts with the negative-disparity K28.5 code 0x0FA.
- R2: The first clock edge after reset release samples beat 0 and the next edge samples beat 1, and groups repeat every two edges. `code_valid` is high for exactly the one cycle that follows the beat-1 edge and is low in the cycle that follows a beat-0 edge.
- R3: The encoded word is ordered as follows: bits 15:12 are lanes 3..0 of the beat-0 rising sample, 11:8 the beat-0 falling sample, 7:4 the beat-1 rising sample and 3:0 the beat-1 falling sample. The high byte is word bits 15:8.
- R4: Each byte is coded with the standard 8b/10b code. Byte bit 0 (a) goes to code bit 9 and the code reads abcdei fghj from bit 9 down to bit 0. The high byte's code is placed in `code_out[19:10]` and the low byte's code in `code_out[9:0]`.
- R5: Running disparity (0 = negative) is applied to the high byte first, then to the low byte, and carries into the next encoded group.
- R6: If lane 4 is 1 in any of the four samples of a group, lanes 3..0 are ignored and both code fields carry the control character as a K code, with disparity chained as in R5.
- R7: The control-character register resets to 0xBC (K28.5) and loads `kchar_wdata` on a cycle with `kchar_we` high. The legal values are K28.0 to K28.7 (low five bits = 28), 0xF7, 0xFB, 0xFD and 0xFE. Any other stored value is sent as K28.5.
- R8: With `bypass` high at the beat-1 edge, `code_out` equals {beat-0 rise[4:0], beat-0 fall[4:0], beat-1 rise[4:0], beat-1 fall[4:0]}. Lane 4 causes no control character, and the running disparity is left unchanged for the next encoded group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_rise | input | 5 | Lane samples taken on the rising half of the period |
| lane_fall | input | 5 | Lane samples taken on the falling half of the period |
| bypass | input | 1 | Raw pass-through for the group, sampled at beat 1 |
| kchar_we | input | 1 | Write strobe for the control-character register |
| kchar_wdata | input | 8 | Control-character value to store |
| code_out | output | 20 | Code group, high byte's code in the upper ten bits |
| code_valid | output | 1 | One-cycle strobe marking a new code group |

## Verification
The assertions assume that the capture stage keeps supplying a sample pair every clock period, and that `bypass` stays constant across the two beats of a group. The bench drives both beats of each group from one task, holds the bypass level for the whole group, and writes the control-character register only during encoded data groups. This keeps a register write from racing the group that uses the character. The stimulus steps the high and low bytes through all 256 values while running disparity drifts. It also places the flag bit in each of the four sample slots, and it writes both legal and illegal control characters.

// File: rtl/ddrnib_pkg.sv
package ddrnib_pkg;

   localparam logic [7:0] KCH_COMMA = 8'hBC;

   function automatic logic kchar_legal(input logic [7:0] k);
      return (k[4:0] == 5'd28) || (k == 8'hF7) || (k == 8'hFB) ||
             (k == 8'hFD) || (k == 8'hFE);
   endfunction

   // negative-disparity 6-bit sub-block, bit 5 = a
   function automatic logic [5:0] sub6_neg(input logic [4:0] x, input logic k);
      logic [5:0] r;
      case (x)
         5'd0:  r = 6'b100111;  5'd1:  r = 6'b011101;
         5'd2:  r = 6'b101101;  5'd3:  r = 6'b110001;
         5'd4:  r = 6'b110101;  5'd5:  r = 6'b101001;
         5'd6:  r = 6'b011001;  5'd7:  r = 6'b111000;
         5'd8:  r = 6'b111001;  5'd9:  r = 6'b100101;
         5'd10: r = 6'b010101;  5'd11: r = 6'b110100;
         5'd12: r = 6'b001101;  5'd13: r = 6'b101100;
         5'd14: r = 6'b011100;  5'd15: r = 6'b010111;
         5'd16: r = 6'b011011;  5'd17: r = 6'b100011;
         5'd18: r = 6'b010011;  5'd19: r = 6'b110010;
         5'd20: r = 6'b001011;  5'd21: r = 6'b101010;
         5'd22: r = 6'b011010;  5'd23: r = 6'b111010;
         5'd24: r = 6'b110011;  5'd25: r = 6'b100110;
         5'd26: r = 6'b010110;  5'd27: r = 6'b110110;
         5'd28: r = k ? 6'b001111 : 6'b001110;
         5'd29: r = 6'b101110;  5'd30: r = 6'b011110;
         default: r = 6'b101011;
      endcase
      return r;
   endfunction

   // 4-bit sub-block in its negative-disparity form, bit 3 = f
   function automatic logic [3:0] sub4_neg(input logic [2:0] y, input logic alt7);
      logic [3:0] r;
      case (y)
         3'd0: r = 4'b1011;
         3'd1: r = 4'b1001;
         3'd2: r = 4'b0101;
         3'd3: r = 4'b1100;
         3'd4: r = 4'b1101;
         3'd5: r = 4'b1010;
         3'd6: r = 4'b0110;
         default: r = alt7 ? 4'b0111 : 4'b1110;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/ddrnib_gather.sv
module ddrnib_gather #(
   parameter int LANES = 5,
   parameter int BEATS = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [LANES-1:0]                 rise_i,
   input  logic [LANES-1:0]                 fall_i,
   output logic                             last_o,
   output logic [2*BEATS*LANES-1:0]         raw_o,
   output logic [2*BEATS*(LANES-1)-1:0]     word_o,
   output logic                             flag_o
);
   localparam int SAMPLES = 2 * BEATS;
   localparam int DLANES  = LANES - 1;
   localparam int RAW_W   = SAMPLES * LANES;
   localparam int PAIR_W  = 2 * LANES;
   localparam int HOLD_W  = (BEATS - 1) * PAIR_W;
   localparam int CNT_W   = (BEATS > 2) ? $clog2(BEATS) : 1;

   logic [CNT_W-1:0]   beat_q;
   logic [HOLD_W-1:0]  hold_q;
   logic [SAMPLES-1:0] flags;

   assign last_o = (beat_q == CNT_W'(BEATS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      beat_q <= '0;
      else if (last_o) beat_q <= '0;
      else             beat_q <= beat_q + 1'b1;
   end

   generate
      if (HOLD_W == PAIR_W) begin : g_hold_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       hold_q <= '0;
            else if (!last_o) hold_q <= {rise_i, fall_i};
         end
      end else begin : g_hold_shift
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       hold_q <= '0;
            else if (!last_o) hold_q <= {hold_q[HOLD_W-PAIR_W-1:0], rise_i, fall_i};
         end
      end
   endgenerate

   assign raw_o = {hold_q, rise_i, fall_i};

   for (genvar s = 0; s < SAMPLES; s++) begin : g_sample
      assign flags[s] = raw_o[RAW_W-1-s*LANES];
      assign word_o[SAMPLES*DLANES-1-s*DLANES -: DLANES] = raw_o[RAW_W-2-s*LANES -: DLANES];
   end

   assign flag_o = |flags;

   AST_BEAT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |=> (beat_q == '0)); // R2

endmodule

// File: rtl/ddrnib_kreg.sv
module ddrnib_kreg
   import ddrnib_pkg::*;
#(
   parameter logic [7:0] DEFAULT_K = KCH_COMMA
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we_i,
   input  logic [7:0] wdata_i,
   output logic [7:0] k_eff_o
);
   logic [7:0] kreg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    kreg_q <= DEFAULT_K;
      else if (we_i) kreg_q <= wdata_i;
   end

   assign k_eff_o = kchar_legal(kreg_q) ? kreg_q : KCH_COMMA;

   AST_KCHAR_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(we_i) && !kchar_legal($past(wdata_i))) |-> (k_eff_o == KCH_COMMA)); // R7

   AST_KCHAR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(we_i) && kchar_legal($past(wdata_i))) |-> (k_eff_o == $past(wdata_i))); // R7

endmodule

// File: rtl/ddrnib_enc8b10b.sv
module ddrnib_enc8b10b
   import ddrnib_pkg::*;
(
   input  logic [7:0] din,
   input  logic       is_k,
   input  logic       rd_in,
   output logic [9:0] dout,
   output logic       rd_out
);
   logic [4:0] x;
   logic [2:0] y;
   logic [5:0] t6, c6;
   logic [3:0] t4, c4;
   logic       unbal6, unbal4, rd_mid, alt7, kflip;

   assign x = din[4:0];
   assign y = din[7:5];

   always_comb begin
      t6     = sub6_neg(x, is_k);
      unbal6 = ($countones(t6) != 3);
      if ((unbal6 || (x == 5'd7 && !is_k)) && rd_in) c6 = ~t6;
      else                                           c6 = t6;
      rd_mid = unbal6 ? ~rd_in : rd_in;

      alt7 = (y == 3'd7) &&
             (is_k ||
              (!rd_mid && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
              ( rd_mid && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
      t4     = sub4_neg(y, alt7);
      unbal4 = ($countones(t4) != 2);
      kflip  = is_k && !unbal4 && (y != 3'd3);
      if (unbal4 || y == 3'd3) c4 = rd_mid ? ~t4 : t4;
      else if (kflip)          c4 = rd_mid ? t4 : ~t4;
      else                     c4 = t4;
      rd_out = unbal4 ? ~rd_mid : rd_mid;
      dout   = {c6, c4};
   end

endmodule

// File: rtl/ddrnib_framer.sv
module ddrnib_framer
   import ddrnib_pkg::*;
#(
   parameter int         LANES      = 5,
   parameter int         BEATS      = 2,
   parameter int         BYTES      = 2,
   parameter bit         HAS_BYPASS = 1'b1,
   parameter logic [7:0] DEFAULT_K  = KCH_COMMA
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [LANES-1:0]       lane_rise,
   input  logic [LANES-1:0]       lane_fall,
   input  logic                   bypass,
   input  logic                   kchar_we,
   input  logic [7:0]             kchar_wdata,
   output logic [BYTES*10-1:0]    code_out,
   output logic                   code_valid
);
   localparam int RAW_W  = 2 * BEATS * LANES;
   localparam int WORD_W = 2 * BEATS * (LANES - 1);
   localparam int CODE_W = BYTES * 10;

   generate
      if (LANES < 2)            begin : g_err_lanes $error("LANES must be at least 2"); end
      if (BEATS < 2)            begin : g_err_beats $error("BEATS must be at least 2"); end
      if (WORD_W != BYTES * 8)  begin : g_err_word  $error("data nibbles must fill whole bytes"); end
      if (RAW_W != CODE_W)      begin : g_err_raw   $error("raw group width must equal code width"); end
   endgenerate

   logic              grp_last, grp_flag, byp_eff, grp_sync;
   logic [RAW_W-1:0]  grp_raw;
   logic [WORD_W-1:0] grp_word;
   logic [7:0]        k_eff;
   logic [CODE_W-1:0] enc_code;
   logic              rd_c [BYTES+1];
   logic              rd_q, valid_q, byp_q;
   logic [CODE_W-1:0] code_q;

   ddrnib_gather #(.LANES(LANES), .BEATS(BEATS)) u_gather (
      .clk    (clk),
      .rst_n  (rst_n),
      .rise_i (lane_rise),
      .fall_i (lane_fall),
      .last_o (grp_last),
      .raw_o  (grp_raw),
      .word_o (grp_word),
      .flag_o (grp_flag)
   );

   ddrnib_kreg #(.DEFAULT_K(DEFAULT_K)) u_kreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (kchar_we),
      .wdata_i (kchar_wdata),
      .k_eff_o (k_eff)
   );

   generate
      if (HAS_BYPASS) begin : g_byp
         assign byp_eff = bypass;
      end else begin : g_nobyp
         logic unused_byp;
         assign unused_byp = bypass;
         assign byp_eff    = 1'b0;
      end
   endgenerate

   assign grp_sync = grp_flag && !byp_eff;
   assign rd_c[0]  = rd_q;

   for (genvar gi = 0; gi < BYTES; gi++) begin : g_byte
      logic [7:0] src;
      assign src = grp_sync ? k_eff : grp_word[WORD_W-1-8*gi -: 8];
      ddrnib_enc8b10b u_enc (
         .din    (src),
         .is_k   (grp_sync),
         .rd_in  (rd_c[gi]),
         .dout   (enc_code[CODE_W-1-10*gi -: 10]),
         .rd_out (rd_c[gi+1])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q  <= '0;
         valid_q <= 1'b0;
         rd_q    <= 1'b0;
         byp_q   <= 1'b0;
      end else if (grp_last) begin
         code_q  <= byp_eff ? grp_raw : enc_code;
         rd_q    <= byp_eff ? rd_q : rd_c[BYTES];
         byp_q   <= byp_eff;
         valid_q <= 1'b1;
      end else begin
         valid_q <= 1'b0;
      end
   end

   assign code_out   = code_q;
   assign code_valid = valid_q;

   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      code_valid |=> !code_valid); // R2

   AST_CODE_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (code_valid && !byp_q) |-> (($countones(code_out[CODE_W-1 -: 10]) >= 4) &&
                                  ($countones(code_out[CODE_W-1 -: 10]) <= 6))); // R4

   AST_RD_RULE: assert property (@(posedge clk) disable iff (!rst_n)
      (code_valid && !byp_q && !$past(rd_q)) |-> ($countones(code_out[CODE_W-1 -: 10]) >= 5)); // R5

   AST_RD_BYPASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (code_valid && byp_q) |-> (rd_q == $past(rd_q))); // R8

endmodule

// File: tb/ddrnib_framer_tb.sv
`timescale 1ns/1ps
module ddrnib_framer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  lane_rise = '0, lane_fall = '0;
   logic        bypass = 1'b0, kchar_we = 1'b0;
   logic [7:0]  kchar_wdata = '0;
   logic [19:0] code_out;
   logic        code_valid;

   int  n_checks = 0, n_fail = 0;
   bit  done = 1'b0;
   logic brd = 1'b0;          // bench running disparity, 1 = positive
   logic [7:0] bk = 8'hBC;    // bench copy of the stored character

   always #10 clk = ~clk;

   ddrnib_framer u_dut (
      .clk(clk), .rst_n(rst_n), .lane_rise(lane_rise), .lane_fall(lane_fall),
      .bypass(bypass), .kchar_we(kchar_we), .kchar_wdata(kchar_wdata),
      .code_out(code_out), .code_valid(code_valid)
   );

   task automatic chk(input logic ok, input string rq, input logic [19:0] act, input logic [19:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%05h expected=%05h", rq, act, exp);
      end
   endtask

   function automatic logic [5:0] six(input logic [4:0] x, input logic k);
      case (x)
         0: return 6'b100111;  1: return 6'b011101;  2: return 6'b101101;  3: return 6'b110001;
         4: return 6'b110101;  5: return 6'b101001;  6: return 6'b011001;  7: return 6'b111000;
         8: return 6'b111001;  9: return 6'b100101; 10: return 6'b010101; 11: return 6'b110100;
        12: return 6'b001101; 13: return 6'b101100; 14: return 6'b011100; 15: return 6'b010111;
        16: return 6'b011011; 17: return 6'b100011; 18: return 6'b010011; 19: return 6'b110010;
        20: return 6'b001011; 21: return 6'b101010; 22: return 6'b011010; 23: return 6'b111010;
        24: return 6'b110011; 25: return 6'b100110; 26: return 6'b010110; 27: return 6'b110110;
        28: return k ? 6'b001111 : 6'b001110;
        29: return 6'b101110; 30: return 6'b011110; default: return 6'b101011;
      endcase
   endfunction

   // returns {disparity after, ten-bit code}
   function automatic logic [10:0] ref_byte(input logic [7:0] b, input logic k, input logic rd_i);
      logic [5:0] s;
      logic [3:0] f;
      logic rd = rd_i;
      logic [4:0] x = b[4:0];
      logic [2:0] y = b[7:5];
      bit a7;
      s = six(x, k);
      if ($countones(s) == 4) begin
         if (rd) s = ~s;
         rd = ~rd;
      end else if (x == 7 && !k && rd) s = ~s;
      a7 = k || (!rd && (x == 17 || x == 18 || x == 20)) || (rd && (x == 11 || x == 13 || x == 14));
      case (y)
         0: f = 4'b1011; 1: f = 4'b1001; 2: f = 4'b0101; 3: f = 4'b1100;
         4: f = 4'b1101; 5: f = 4'b1010; 6: f = 4'b0110; default: f = a7 ? 4'b0111 : 4'b1110;
      endcase
      if ($countones(f) != 2) begin
         if (rd) f = ~f;
         rd = ~rd;
      end else if (y == 3) begin
         if (rd) f = ~f;
      end else if (k && !rd) f = ~f;
      return {rd, s, f};
   endfunction

   function automatic logic [7:0] k_used(input logic [7:0] v);
      if (v[4:0] == 5'd28 || v == 8'hF7 || v == 8'hFB || v == 8'hFD || v == 8'hFE) return v;
      return 8'hBC;
   endfunction

   function automatic logic [19:0] raw_of(input logic [15:0] w);
      return {1'b0, w[15:12], 1'b0, w[11:8], 1'b0, w[7:4], 1'b0, w[3:0]};
   endfunction

   task automatic exp_pair(input logic [7:0] hi, input logic [7:0] lo, input logic k, output logic [19:0] e);
      logic [10:0] r1, r2;
      r1  = ref_byte(hi, k, brd);
      r2  = ref_byte(lo, k, r1[10]);
      brd = r2[10];
      e   = {r1[9:0], r2[9:0]};
   endtask

   // one group: beat 0 then beat 1, checks the strobe gap and the result
   task automatic run_group(input logic [19:0] raw, input logic byp, input logic we,
                            input logic [7:0] wd, input logic [19:0] exp, input string rq);
      bypass = byp; kchar_we = we; kchar_wdata = wd;
      lane_rise = raw[19:15]; lane_fall = raw[14:10];
      @(posedge clk); @(negedge clk);
      chk(code_valid == 1'b0, "R2 no strobe after beat 0", {19'd0, code_valid}, 20'd0);
      kchar_we = 1'b0;
      lane_rise = raw[9:5]; lane_fall = raw[4:0];
      @(posedge clk); @(negedge clk);
      chk(code_valid == 1'b1, "R2 strobe after beat 1", {19'd0, code_valid}, 20'd1);
      chk(code_out == exp, rq, code_out, exp);
   endtask

   task automatic data_group(input logic [15:0] w, input string rq);
      logic [19:0] e;
      exp_pair(w[15:8], w[7:0], 1'b0, e);
      run_group(raw_of(w), 1'b0, 1'b0, 8'h00, e, rq);
   endtask

   task automatic write_k(input logic [7:0] v);
      logic [19:0] e;
      exp_pair(8'hC3, 8'h3C, 1'b0, e);
      run_group(raw_of(16'hC33C), 1'b0, 1'b1, v, e, "R7 data group carrying register write");
      bk = v;
   endtask

   task automatic sync_group(input logic [19:0] noise, input int slot, input string rq);
      logic [19:0] e, raw;
      logic [7:0] kc;
      kc  = k_used(bk);
      exp_pair(kc, kc, 1'b1, e);
      raw = noise;
      raw[19 - 5*slot] = 1'b1;
      run_group(raw, 1'b0, 1'b0, 8'h00, e, rq);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [19:0] e;
      repeat (3) @(negedge clk);
      chk(code_valid == 1'b0, "R1 strobe low in reset", {19'd0, code_valid}, 20'd0);
      chk(code_out == 20'd0, "R1 code zero in reset", code_out, 20'd0);
      rst_n = 1'b1;
      chk(code_valid == 1'b0, "R1 strobe low after reset", {19'd0, code_valid}, 20'd0);

      // R1 R6: first comma pair from negative disparity, fixed constant
      sync_group(20'h00000, 0, "R1 first comma group");
      // expected constant check of the same output
      chk(code_out == {10'h0FA, 10'h305}, "R1 K28.5 pair constant", code_out, {10'h0FA, 10'h305});

      // R4 constant: D21.5 in both bytes
      data_group(16'hB5B5, "R4 D21.5 pair");
      chk(code_out == {10'h2AA, 10'h2AA}, "R4 D21.5 constant", code_out, {10'h2AA, 10'h2AA});

      // R3 nibble order with distinct nibbles
      data_group(16'h1234, "R3 nibble order 1234");
      data_group(16'h8E71, "R3 nibble order 8E71");

      // R4 R5 sweeps: every high byte and every low byte
      for (int i = 0; i < 256; i++)
         data_group({i[7:0], 8'(255 - i)}, "R4 R5 high byte sweep");
      for (int i = 0; i < 256; i++)
         data_group({8'(i * 37 + 11), i[7:0]}, "R4 R5 low byte sweep");

      // R6: flag in each slot, data lanes carry noise
      for (int s = 0; s < 4; s++)
         sync_group(20'h5ADEF & 20'h7BDEF, s, "R6 flag slot sweep");
      data_group(16'h0F0F, "R5 data after comma");

      // R7: programmed characters and fallback
      write_k(8'hFC);
      sync_group(20'h18C63, 2, "R7 K28.7");
      write_k(8'hF7);
      sync_group(20'h0, 1, "R7 K23.7");
      write_k(8'h3C);
      sync_group(20'h0, 3, "R7 K28.1");
      write_k(8'h55);
      sync_group(20'h0, 0, "R7 illegal falls back to K28.5");
      write_k(8'hFE);
      sync_group(20'h0, 2, "R7 K30.7");

      // R8: raw pass-through, lane 4 included, disparity kept
      for (int i = 0; i < 24; i++) begin
         e = 20'(32'h9E3B5 * (i + 1)) ^ 20'(i << 15);
         run_group(e, 1'b1, 1'b0, 8'h00, e, "R8 bypass raw");
      end
      run_group(20'hFFFFF, 1'b1, 1'b0, 8'h00, 20'hFFFFF, "R8 bypass all ones");
      data_group(16'hA7C1, "R8 disparity kept across bypass");
      data_group(16'h1C00, "R5 carry into next group");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule